// File: doc/BRIEF.md
# Four-Output PWM Group with Center and Edge Alignment

This block produces four switching waveforms from one shared period counter, arranged as two pairs (pair A and pair B, each with a high-side and a low-side output). Software-style register writes set one period value and four duty values. The counter runs either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each pair either drives its low side as the inverse of its high side, or drives both sides independently from their own duty values.

All writes land in shadow registers. The active copies that the comparators use are refreshed only at set points in the cycle. The first is the period restart. When double update is selected in center-aligned mode, the duty values are also refreshed at the counter turnaround, so the two halves of a pulse can differ. A one-cycle strobe marks each period start, and a second strobe marks the turnaround.

The register write port is a plain one-cycle write strobe with no back-pressure: every write is accepted in the cycle it is presented. The mode inputs are meant to change only while `en` is low. Periods of 1 or more are supported.

Top module: `pwm_quad_group`

## Requirements
- R1: After a synchronous active-high reset, every shadow and active register is zero, the counter is zero, and `pwm_out`, `period_start` and `mid_point` are all low.
- R2: While `en` is low, all four outputs and both strobes are low and the counter is held at zero. The active registers follow the shadow registers every cycle.
- R3: With `center_mode` low, the counter steps 0,1,…,P-1 and then restarts, where P is the active period. An output is high while the count is below its duty, so a high-side output is high for D cycles of every P.
- R4: With `center_mode` high, the counter steps 0,1,…,P,P-1,…,1 and then restarts, giving a period of 2P cycles. An output is high while the count is below its duty.
- R5: A duty of 0 keeps its output low for the whole period. A duty at or above the active period keeps it high for the whole period.
- R6: For a pair whose `pair_indep` bit is low, the low-side output is the inverse of the high-side output while `en` is high.
- R7: For a pair whose `pair_indep` bit is high, the low-side output follows the same compare rule using its own duty register.
- R8: A write changes only a shadow register. The active period and duties are copied from the shadows on the cycle that the counter restarts, so a write made mid-period has no effect on the outputs until the next period.
- R9: With `center_mode` and `double_upd` both high, the active duties are also copied from the shadows on the cycle that the counter reaches the turnaround value P.
- R10: `period_start` is high for exactly the cycle in which the counter is 0 at the start of a period. `mid_point` is high only in center-aligned mode, and only for the cycle in which the counter equals P.
- R11: Register addresses are 0 for the period, 1 for the A high-side duty, 2 for the A low-side duty, 3 for the B high-side duty and 4 for the B low-side duty. Writes to addresses 5 to 7 change nothing. `pwm_out` bits 0 to 3 are A-high, A-low, B-high and B-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the counter and forces outputs low |
| center_mode | input | 1 | 1 = triangle counting, 0 = sawtooth counting |
| double_upd | input | 1 | 1 = also reload duties at the turnaround (center mode only) |
| pair_indep | input | 2 | Per pair: 1 = independent low side, 0 = complementary |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| pwm_out | output | 4 | A-high, A-low, B-high, B-low (bits 0..3) |
| period_start | output | 1 | One-cycle strobe at each counter restart |
| mid_point | output | 1 | One-cycle strobe at the center-aligned turnaround |

## Verification
The bench builds the group with an 8-bit counter. This keeps periods of 5 to 8 counts short enough that both counter shapes, their restart and turnaround points, and several update points fit within a few hundred cycles. Duties are chosen at 0, inside the period, equal to the period and above it. Writes are timed to fall before and after the turnaround, so the difference between single and double update shows up in the outputs.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;
  localparam int ADDR_W   = 3;
  localparam int NUM_OUT  = 4;
  localparam int NUM_PAIR = NUM_OUT / 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PERIOD = 3'd0,
    REG_A_HI   = 3'd1,
    REG_A_LO   = 3'd2,
    REG_B_HI   = 3'd3,
    REG_B_LO   = 3'd4
  } reg_addr_e;

  localparam logic [ADDR_W-1:0] DUTY_BASE = REG_A_HI;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [CNT_W-1:0]                  wr_data,
  input  logic                              load_bound,
  input  logic                              load_mid,
  output logic [CNT_W-1:0]                  per_act,
  output logic [NUM_OUT-1:0][CNT_W-1:0]     duty_act
);
  logic [CNT_W-1:0] per_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      per_sh  <= '0;
      per_act <= '0;
    end else begin
      if (load_bound) per_act <= per_sh;
      if (wr_en && wr_addr == REG_PERIOD) per_sh <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_duty
    logic [CNT_W-1:0] duty_sh;
    logic             sel;
    assign sel = wr_en && (wr_addr == DUTY_BASE + ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        duty_sh     <= '0;
        duty_act[i] <= '0;
      end else begin
        if (load_bound || load_mid) duty_act[i] <= duty_sh;
        if (sel) duty_sh <= wr_data;
      end
    end
  end

  // R8: actives move only at a permitted update point
  p_duty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!load_bound && !load_mid) |=> $stable(duty_act));
  p_per_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !load_bound |=> $stable(per_act));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             center,
  input  logic             dbl,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             load_bound,
  output logic             load_mid,
  output logic             start_stb,
  output logic             mid_stb
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             down, nxt_down;
  logic [CNT_W-1:0] nxt_cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    nxt_cnt    = cnt;
    nxt_down   = down;
    load_bound = 1'b0;
    load_mid   = 1'b0;
    if (!en) begin
      nxt_cnt    = '0;
      nxt_down   = 1'b0;
      load_bound = 1'b1;
    end else if (!center) begin
      nxt_down = 1'b0;
      if (cnt_inc >= {1'b0, per}) begin
        nxt_cnt    = '0;
        load_bound = 1'b1;
      end else begin
        nxt_cnt = cnt_inc[CNT_W-1:0];
      end
    end else if (down || cnt >= per) begin
      if (cnt <= ONE) begin
        nxt_cnt    = '0;
        nxt_down   = 1'b0;
        load_bound = 1'b1;
      end else begin
        nxt_cnt  = cnt - ONE;
        nxt_down = 1'b1;
      end
    end else begin
      nxt_cnt  = cnt_inc[CNT_W-1:0];
      nxt_down = 1'b0;
      load_mid = dbl && (cnt_inc == {1'b0, per});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      down <= 1'b0;
    end else begin
      cnt  <= nxt_cnt;
      down <= nxt_down;
    end
  end

  assign start_stb = en && !down && (cnt == '0);
  assign mid_stb   = en && center && !down && (cnt == per);

  // R2: a disabled group restarts from zero
  p_hold_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> cnt == '0);
  // R3: sawtooth stays below the period
  p_edge_range_r3: assert property (@(posedge clk) disable iff (rst)
    (en && !center && per != '0) |-> cnt < per);
  // R4: triangle never passes the period value
  p_center_range_r4: assert property (@(posedge clk) disable iff (rst)
    (en && center) |-> cnt <= per);
  // R10: restart strobe lasts one cycle when the period exceeds one
  p_start_single_r10: assert property (@(posedge clk) disable iff (rst)
    (start_stb && per > ONE && $stable(en)) |=> !start_stb);
  p_mid_center_r10: assert property (@(posedge clk) disable iff (rst)
    mid_stb |-> center);
endmodule

// File: rtl/pwm_pair_out.sv
module pwm_pair_out #(
  parameter int CNT_W = 16
) (
  input  logic             en,
  input  logic             indep,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] per,
  input  logic [CNT_W-1:0] duty_hi,
  input  logic [CNT_W-1:0] duty_lo,
  output logic             out_hi,
  output logic             out_lo
);
  logic lvl_hi, lvl_lo;

  assign lvl_hi = (cnt < duty_hi) || (duty_hi >= per);
  assign lvl_lo = (cnt < duty_lo) || (duty_lo >= per);

  assign out_hi = en && lvl_hi;
  assign out_lo = en && (indep ? lvl_lo : !lvl_hi);

  // R6: complementary pair never drives both sides alike
  always_comb begin
    if (en && !indep) begin
      p_pair_comp_r6: assert (out_hi != out_lo);
    end
  end
endmodule

// File: rtl/pwm_quad_group.sv
module pwm_quad_group
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic                 center_mode,
  input  logic                 double_upd,
  input  logic [1:0]           pair_indep,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output logic [3:0]           pwm_out,
  output logic                 period_start,
  output logic                 mid_point
);
  logic [CNT_W-1:0]              cnt, per_act;
  logic [NUM_OUT-1:0][CNT_W-1:0] duty_act;
  logic                          load_bound, load_mid;

  pwm_shadow_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load_bound(load_bound), .load_mid(load_mid),
    .per_act(per_act), .duty_act(duty_act)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en),
    .center(center_mode), .dbl(double_upd), .per(per_act),
    .cnt(cnt), .load_bound(load_bound), .load_mid(load_mid),
    .start_stb(period_start), .mid_stb(mid_point)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    pwm_pair_out #(.CNT_W(CNT_W)) u_pair (
      .en(en), .indep(pair_indep[p]), .cnt(cnt), .per(per_act),
      .duty_hi(duty_act[2*p]), .duty_lo(duty_act[2*p+1]),
      .out_hi(pwm_out[2*p]), .out_lo(pwm_out[2*p+1])
    );
  end

  // R2: disabled group is silent
  p_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !en |-> (pwm_out == 4'b0 && !period_start && !mid_point));
  // R1: one cycle after reset, nothing is driven
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pwm_out == 4'b0 && !mid_point));
endmodule

// File: tb/sim_pwm_quad_group.sv
module sim_pwm_quad_group;
  localparam int W = 8;

  logic         clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic         center_mode = 1'b0, double_upd = 1'b0;
  logic [1:0]   pair_indep = 2'b00;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [3:0]   pwm_out;
  logic         period_start, mid_point;

  int tests = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  pwm_quad_group #(.CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .en(en), .center_mode(center_mode),
    .double_upd(double_upd), .pair_indep(pair_indep),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .period_start(period_start), .mid_point(mid_point)
  );

  // behavioural reference state
  int m_cnt, m_dn, m_per, s_per;
  int m_d[4];
  int s_d[4];

  always @(posedge clk) begin
    bit lb, lm;
    lb = 0; lm = 0;
    if (rst) begin
      m_cnt = 0; m_dn = 0; m_per = 0; s_per = 0;
      for (int i = 0; i < 4; i++) begin m_d[i] = 0; s_d[i] = 0; end
    end else begin
      if (!en) begin
        m_cnt = 0; m_dn = 0; lb = 1;
      end else if (!center_mode) begin
        m_dn = 0;
        if (m_cnt + 1 >= m_per) begin m_cnt = 0; lb = 1; end
        else m_cnt = m_cnt + 1;
      end else if (m_dn != 0 || m_cnt >= m_per) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_dn = 0; lb = 1; end
        else begin m_cnt = m_cnt - 1; m_dn = 1; end
      end else begin
        m_cnt = m_cnt + 1;
        lm = double_upd && (m_cnt == m_per);
      end
      if (lb) m_per = s_per;
      if (lb || lm) for (int i = 0; i < 4; i++) m_d[i] = s_d[i];
      if (wr_en) begin
        if (wr_addr == 3'd0) s_per = int'(wr_data);
        else if (wr_addr <= 3'd4) s_d[int'(wr_addr) - 1] = int'(wr_data);
      end
    end
  end

  function automatic bit lvl(int d);
    return en && (m_cnt < d || d >= m_per);
  endfunction

  task automatic compare();
    logic [3:0] e;
    logic es, em;
    e[0] = lvl(m_d[0]);
    e[1] = pair_indep[0] ? lvl(m_d[1]) : (en && !lvl(m_d[0]));
    e[2] = lvl(m_d[2]);
    e[3] = pair_indep[1] ? lvl(m_d[3]) : (en && !lvl(m_d[2]));
    es = en && m_cnt == 0 && m_dn == 0;
    em = en && center_mode && m_dn == 0 && m_cnt == m_per;
    tests++;
    if (pwm_out !== e || period_start !== es || mid_point !== em) begin
      fails++;
      $display("FAIL %s: out=%b start=%b mid=%b expected out=%b start=%b mid=%b",
               tag, pwm_out, period_start, mid_point, e, es, em);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = W'(d);
    step();
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) step();
  endtask

  task automatic check_cnt(input string t, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: count=%0d expected %0d", t, got, exp);
    end
  endtask

  task automatic restart(input logic c, input logic d, input logic [1:0] pi);
    en = 1'b0; step();
    center_mode = c; double_upd = d; pair_indep = pi;
    step();
    en = 1'b1;
  endtask

  initial begin
    int n_hi, n_lo, n_st, n_mid;
    // R1: reset state
    run(3);
    rst = 1'b0;
    tag = "R1"; step();
    tests++;
    if (pwm_out !== 4'b0 || period_start !== 1'b0 || mid_point !== 1'b0) begin
      fails++;
      $display("FAIL R1: out=%b start=%b mid=%b expected 0000 0 0", pwm_out, period_start, mid_point);
    end

    // R2: disabled, registers programmed, outputs stay low
    tag = "R2";
    wr(3'd0, 8); wr(3'd1, 3); wr(3'd2, 5); wr(3'd3, 6); wr(3'd4, 2);
    run(6);

    // R3 / R6: sawtooth, complementary pairs
    tag = "R3"; restart(1'b0, 1'b0, 2'b00);
    n_hi = 0; n_lo = 0; n_st = 0;
    repeat (16) begin step(); n_hi += pwm_out[0]; n_lo += pwm_out[1]; n_st += period_start; end
    check_cnt("R3 A-high cycles over two periods", n_hi, 6);
    check_cnt("R6 A-low cycles over two periods", n_lo, 10);
    check_cnt("R10 edge starts", n_st, 2);

    // R5: duty 0 and duty above period
    tag = "R5";
    wr(3'd1, 0); wr(3'd3, 9); run(10);
    n_hi = 0; n_lo = 0;
    repeat (16) begin step(); n_hi += pwm_out[0]; n_lo += pwm_out[2]; end
    check_cnt("R5 duty zero stays low", n_hi, 0);
    check_cnt("R5 duty above period stays high", n_lo, 16);
    wr(3'd3, 8); run(20);

    // R7: pair A independent
    tag = "R7"; wr(3'd1, 3); restart(1'b0, 1'b0, 2'b01);
    n_lo = 0;
    repeat (16) begin step(); n_lo += pwm_out[1]; end
    check_cnt("R7 A-low follows own duty", n_lo, 10);

    // R4: triangle, single update
    tag = "R4"; wr(3'd0, 6); wr(3'd1, 2); restart(1'b1, 1'b0, 2'b00);
    n_hi = 0; n_st = 0; n_mid = 0;
    repeat (24) begin step(); n_hi += pwm_out[0]; n_st += period_start; n_mid += mid_point; end
    check_cnt("R4 A-high cycles over two periods", n_hi, 6);
    check_cnt("R10 center starts", n_st, 2);
    check_cnt("R10 center mids", n_mid, 2);

    // R8: mid-period writes in single update
    tag = "R8";
    for (int k = 0; k < 12; k++) begin
      run(k % 5);
      wr(3'd1, k % 7); wr(3'd4, (k * 3) % 8);
    end
    run(30);

    // R9: double update with writes around the turnaround
    tag = "R9"; restart(1'b1, 1'b1, 2'b10);
    for (int k = 0; k < 14; k++) begin
      run(k % 4);
      wr(3'd1, (k * 5) % 8); wr(3'd3, (k * 2) % 7); wr(3'd4, k % 6);
    end
    run(30);

    // R11: unused addresses change nothing; period changes at restart
    tag = "R11";
    wr(3'd5, 1); wr(3'd6, 0); wr(3'd7, 3); run(30);
    wr(3'd0, 5); run(30);
    tag = "R3"; restart(1'b0, 1'b0, 2'b11); run(30);

    // R2: dropping enable silences everything
    tag = "R2"; en = 1'b0; run(8);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule